// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits beside the access controller of an asynchronous DRAM and takes care of everything that keeps the array alive. After reset it waits out a long power-up pause. It then runs a fixed burst of column-before-row refresh cycles and raises `ready`. From that point on, an interval timer asks for one refresh every period, sized so that all 2048 rows are covered inside the retention time. At the default 125 MHz clock that is 1950 cycles, or about 15.6 µs.

Each refresh needs the shared DRAM pins, so the sequencer raises `req` and waits for `grant`. Once granted, it drives the strobes through one complete cycle. A request is never lost. Intervals that expire while the controller holds the bus are counted, up to a saturation limit. They are then worked off back to back, with one idle cycle between refreshes. While `req` is high and `grant` has been given, the controller must leave the strobes alone.

Two refresh styles are offered. The default lets the DRAM advance its own row counter: the column strobe falls before the row strobe and write enable is held high, so the device never mistakes the cycle for a test-mode entry. The alternative drives an address from an internal 11-bit row counter and pulses only the row strobe. All timings are parameters in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are high, and `req` and `ready` are low.
- R2: After reset is released, the first strobe activity (`cas_n` falling) happens on the rising edge numbered `T_INIT`, counting the first edge with reset released as edge 1.
- R3: The power-up burst is exactly `INIT_BURST` column-before-row cycles, used even when `mode_ras_only` is 1. `ready` rises at edge `T_INIT + INIT_BURST*(T_SETUP+T_RAS+T_PRE)` and stays high.
- R4: In a column-before-row cycle, `cas_n` is low for exactly `T_SETUP` cycles before `ras_n` falls. It then stays low for exactly `T_HOLD` cycles of the `T_RAS`-cycle low phase of `ras_n`.
- R5: `we_n` is high at all times.
- R6: `ras_n` stays low for exactly `T_RAS` cycles in every refresh and stays high for at least `T_PRE` cycles between refreshes. Within the power-up burst, the high time is exactly `T_PRE+T_SETUP`.
- R7: The interval timer starts when `ready` rises. `req` goes high `T_INT` cycles later.
- R8: Without `grant` no refresh begins: the strobes stay high and `req` stays high. Whenever `ready` is high and `req` is low, both strobes are high.
- R9: Pending refreshes run back to back while `grant` is held. Between two of them `ras_n` is high for exactly `T_PRE+1+T_SETUP` cycles.
- R10: The count of pending refreshes saturates at `2**MISS_W-1`. Once that many have been performed, `req` falls and no further cycle starts until the next interval expires.
- R11: A cycle started with `mode_ras_only`=1 keeps `cas_n` high throughout. `row_addr` is stable while `ras_n` is low and equals the number of such cycles completed before it, modulo 2048.
- R12: `row_addr` advances by one after each row-strobe-only cycle and wraps from 2047 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ras_only | input | 1 | 1 selects row-strobe-only refresh; sampled when a granted cycle starts |
| grant | input | 1 | Access controller releases the DRAM pins |
| req | output | 1 | Refresh pending or in progress |
| ready | output | 1 | Power-up sequence complete |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| we_n | output | 1 | Write enable to the DRAM, held high |
| row_addr | output | ROW_W | Row address for row-strobe-only refresh |

## Verification
The bench holds `mode_ras_only` high through power-up. A design that let the mode reach the power-up burst would drop the column strobe out of those cycles, and the check on the setup run would catch it. Grant is then withheld for five intervals with a three-deep pending count. A counter that wraps instead of saturating would replay too few or too many refreshes, and one that drops requests would leave `req` low. The row-strobe-only run goes through all 2049 cycles, so an address that skips, repeats or fails to wrap at 2047 shows up at the exact cycle where it happens. Exact high-time counts between refreshes expose an extra or missing idle cycle in the back-to-back path.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int T_INIT     = 25_000_000,
  parameter int T_INT      = 1950,
  parameter int T_SETUP    = 2,
  parameter int T_RAS      = 7,
  parameter int T_HOLD     = 2,
  parameter int T_PRE      = 4,
  parameter int INIT_BURST = 8,
  parameter int ROW_W      = 11,
  parameter int MISS_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ras_only,
  input  logic             grant,
  output logic             req,
  output logic             ready,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);
  localparam int MAXT  = (T_INIT > T_RAS) ? ((T_INIT > T_PRE) ? T_INIT : T_PRE)
                                          : ((T_RAS > T_PRE) ? T_RAS : T_PRE);
  localparam int CNT_W = $clog2(MAXT + 1) + 1;
  localparam int TMR_W = $clog2(T_INT + 1);
  localparam int BW    = $clog2(INIT_BURST + 1);
  localparam logic [MISS_W-1:0] PEND_MAX = {MISS_W{1'b1}};

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_SETUP, S_ACT, S_PRE} st_t;

  st_t               st, st_d;
  logic [CNT_W-1:0]  cnt, cnt_d;
  logic [BW-1:0]     boot, boot_d;
  logic              rdy_d, ronly, ronly_d;
  logic [ROW_W-1:0]  row, row_d;
  logic [TMR_W-1:0]  tmr;
  logic [MISS_W-1:0] pend, pend_d;
  logic              tick, start;

  assign tick     = ready && (tmr == '0);
  assign start    = (st == S_IDLE) && (pend != '0) && grant;
  assign req      = ready && ((pend != '0) || (st != S_IDLE));
  assign we_n     = 1'b1;
  assign row_addr = row;

  always_comb begin
    st_d    = st;
    cnt_d   = (cnt != '0) ? cnt - CNT_W'(1) : cnt;
    boot_d  = boot;
    rdy_d   = ready;
    ronly_d = ronly;
    row_d   = row;
    case (st)
      S_INIT: if (cnt == '0) begin
        st_d    = S_SETUP;
        cnt_d   = CNT_W'(T_SETUP - 1);
        boot_d  = BW'(INIT_BURST);
        ronly_d = 1'b0;
      end
      S_IDLE: if (start) begin
        st_d    = S_SETUP;
        cnt_d   = CNT_W'(T_SETUP - 1);
        ronly_d = mode_ras_only;
      end
      S_SETUP: if (cnt == '0) begin
        st_d  = S_ACT;
        cnt_d = CNT_W'(T_RAS - 1);
      end
      S_ACT: if (cnt == '0) begin
        st_d  = S_PRE;
        cnt_d = CNT_W'(T_PRE - 1);
      end
      S_PRE: if (cnt == '0) begin
        if (ronly) row_d = row + ROW_W'(1);
        if (boot > BW'(1)) begin
          boot_d = boot - BW'(1);
          st_d   = S_SETUP;
          cnt_d  = CNT_W'(T_SETUP - 1);
        end else begin
          boot_d = '0;
          rdy_d  = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_INIT;
    endcase
  end

  always_comb begin
    pend_d = pend;
    if (tick && !start && pend != PEND_MAX) pend_d = pend + MISS_W'(1);
    else if (start && !tick)               pend_d = pend - MISS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_INIT;
      cnt   <= CNT_W'(T_INIT - 1);
      boot  <= '0;
      ready <= 1'b0;
      ronly <= 1'b0;
      row   <= '0;
      pend  <= '0;
      tmr   <= TMR_W'(T_INT - 1);
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      st    <= st_d;
      cnt   <= cnt_d;
      boot  <= boot_d;
      ready <= rdy_d;
      ronly <= ronly_d;
      row   <= row_d;
      pend  <= pend_d;
      tmr   <= (!ready || tmr == '0) ? TMR_W'(T_INT - 1) : tmr - TMR_W'(1);
      ras_n <= !(st_d == S_ACT);
      cas_n <= !(!ronly_d && ((st_d == S_SETUP) ||
                 ((st_d == S_ACT) && (cnt_d >= CNT_W'(T_RAS - T_HOLD)))));
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             req,
  input logic             ready,
  input logic [ROW_W-1:0] row_addr
);
  p_cas_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

  p_cas_fall_ras_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n);

  p_ras_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> !ras_n);

  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !req) |-> (ras_n && cas_n));

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> $stable(row_addr));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
  .req(req), .ready(ready), .row_addr(row_addr)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int T_INIT = 50, T_INT = 60, T_SETUP = 2, T_RAS = 7, T_HOLD = 2;
  localparam int T_PRE = 4, INIT_BURST = 8, ROW_W = 11, MISS_W = 2;
  localparam int CYC_LEN = T_SETUP + T_RAS + T_PRE;
  localparam int E_RDY = T_INIT + INIT_BURST * CYC_LEN;

  logic clk = 1'b0, rst_n = 1'b0, mode_ras_only = 1'b1, grant = 1'b0;
  logic req, ready, ras_n, cas_n, we_n;
  logic [ROW_W-1:0] row_addr;
  int cyc = 0, checks = 0, errors = 0, we_low = 0;

  always #4 clk = ~clk;

  dram_refresh_seq #(.T_INIT(T_INIT), .T_INT(T_INT), .T_SETUP(T_SETUP), .T_RAS(T_RAS),
    .T_HOLD(T_HOLD), .T_PRE(T_PRE), .INIT_BURST(INIT_BURST), .ROW_W(ROW_W),
    .MISS_W(MISS_W)) i_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .mode_ras_only(mode_ras_only), .grant(grant),
    .req(req), .ready(ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .row_addr(row_addr));

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && !we_n) we_low++;

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic observe(input bit cbr, input int exp_addr, input int gap, input string r);
    int pre_cas = 0, hi = 0, lo = 0, hold = 0, guard = 0;
    while (ras_n && guard < 400) begin
      hi++;
      if (!cas_n) pre_cas++; else pre_cas = 0;
      guard++;
      @(negedge clk);
    end
    chk({r, " ras fell"}, guard < 400, 1);
    if (gap > 0) chk({r, " R6/R9 high gap"}, hi, gap);
    if (gap == 0) chk({r, " R6 min precharge"}, hi >= T_PRE, 1);
    if (cbr) chk("R4 cas setup", pre_cas, T_SETUP);
    else begin
      chk("R11 cas high before ras", pre_cas, 0);
      chk(r, row_addr, exp_addr);
    end
    while (!ras_n && lo < 400) begin
      lo++;
      if (!cas_n) hold++;
      @(negedge clk);
    end
    chk("R6 ras low width", lo, T_RAS);
    chk(cbr ? "R4 cas hold" : "R11 cas high during ras", hold, cbr ? T_HOLD : 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 ras_n", ras_n, 1); chk("R1 cas_n", cas_n, 1); chk("R1 we_n", we_n, 1);
    chk("R1 req", req, 0);     chk("R1 ready", ready, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_init();
    int guard = 0;
    @(negedge clk);
    while (cas_n && guard < 200) begin guard++; @(negedge clk); end
    chk("R2 first strobe edge", cyc, T_INIT);
    for (int i = 0; i < INIT_BURST; i++) begin
      observe(1'b1, 0, (i == 0) ? -1 : T_PRE + T_SETUP, "R3 burst");
      chk("R3 not ready during burst", ready, 0);
    end
    guard = 0;
    while (!ready && ras_n && guard < 200) begin guard++; @(negedge clk); end
    chk("R3 no extra burst cycle", ras_n, 1);
    chk("R3 ready edge", cyc, E_RDY);
    chk("R7 req low at ready", req, 0);
  endtask

  task automatic t_timer();
    int guard = 0;
    while (!req && guard < 200) begin guard++; @(negedge clk); end
    chk("R7 first request edge", cyc, E_RDY + T_INT);
  endtask

  task automatic t_nogrant();
    int bad = 0;
    while (cyc < E_RDY + 5 * T_INT + 10) begin
      if (!ras_n || !cas_n || !req) bad++;
      @(negedge clk);
    end
    chk("R8 no cycle and req held without grant", bad, 0);
  endtask

  task automatic t_catchup();
    int extra = 0;
    mode_ras_only = 1'b0;
    grant = 1'b1;
    observe(1'b1, 0, -1, "R9 first");
    observe(1'b1, 0, T_PRE + 1 + T_SETUP, "R9 second");
    observe(1'b1, 0, T_PRE + 1 + T_SETUP, "R9 third");
    while (cyc < E_RDY + 6 * T_INT - 2) begin
      if (!ras_n) extra++;
      @(negedge clk);
    end
    chk("R10 saturated backlog, no fourth cycle", extra, 0);
    chk("R10 req low after backlog", req, 0);
    chk("R3 ready still high", ready, 1);
  endtask

  task automatic t_ras_only();
    mode_ras_only = 1'b1;
    for (int i = 0; i <= 2048; i++)
      observe(1'b0, i % 2048, (i == 0) ? -1 : 0, (i >= 2047) ? "R12 wrap address" : "R11 address");
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 180000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_timer();
    t_nogrant();
    t_catchup();
    t_ras_only();
    chk("R5 we_n never low", we_low, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule